// File: doc/BRIEF.md
# Affinity Routing Table for Shared Interrupts

This block holds one 64-bit routing register for each shared interrupt, reached over a simple 32-bit register bus. The lower half of each register holds a packed four-level affinity value. The upper half is permanently zero. When an affinity is written, the block compares it with a fixed table of core affinities that is set as a parameter. It records which core the interrupt now targets and keeps, for every core, a bitmap of the shared interrupts routed to it. Downstream delivery logic reads the target index, the valid flag and the per-core bitmaps straight from the outputs.

An affinity that matches no core is still stored and read back exactly as written. The interrupt is marked unroutable: it may become pending but is never delivered. Each accepted write runs through a three-state sequencer. In ST_IDLE the bus is accepted. An accepted write to the lower half of an in-range entry moves the sequencer to ST_UNLINK, which clears the interrupt's bit in the bitmap of the core it targeted before. ST_UNLINK always moves on to ST_LINK. ST_LINK looks up the new affinity, records the target, sets the new core's bitmap bit and returns to ST_IDLE. Reads and ignored writes leave the sequencer in ST_IDLE.

Top module: `aff_route_table`

## Requirements
- R1: After reset, every entry reads back core 0's affinity and targets index 0 with valid set. Core 0's bitmap is all ones and every other bitmap is zero. busy, rd_valid and route_changed are low.
- R2: Entry i has its lower half at byte offset 0x100+8*i and its upper half at 0x104+8*i. A read accepted on a clock edge gives rd_valid and rd_data in the following cycle.
- R3: A read of a lower half returns the full 32-bit value last written, with level 0 in [7:0], level 1 in [15:8], level 2 in [23:16] and level 3 in [31:24]. This holds whether or not the value matches a core.
- R4: Reads of an upper half, of any offset below 0x100, or of any offset past the last entry return zero. Writes to those places change no state and do not raise busy.
- R5: After a write whose value equals all 32 bits of a core table entry, the target index is that core's number (the lowest such number if several match), zero-extended to 8 bits, and valid is 1.
- R6: Each interrupt's bit is set in exactly the bitmap of its target core, and in no bitmap when it is unroutable. A write clears the old core's bit and sets the new core's bit, leaving other interrupts untouched.
- R7: After a write whose value matches no core, the target index is 0xFF and valid is 0.
- R8: After an accepted write, busy is high for exactly two cycles. route_changed is high for exactly one cycle, the first cycle in which busy is low again, and by then all outputs show the new routing.
- R9: Any access presented while busy is high is ignored. It gives no read response and makes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the routing region |
| bus_wdata | input | 32 | Write data |
| busy | output | 1 | Sequencer is updating routing; accesses are ignored |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| tgt_idx | output | 8*NUM_SPI | Target core index per interrupt, 0xFF when unroutable |
| tgt_valid | output | NUM_SPI | Interrupt has a target core |
| core_map | output | NUM_CORES*NUM_SPI | Bitmap of core c at [c*NUM_SPI +: NUM_SPI] |
| route_changed | output | 1 | One-cycle pulse when a routing update completes |

## Verification
Some properties are checked on every cycle. Each interrupt outside the update in flight has a bitmap column with exactly as many set bits as its valid flag. A cleared valid flag always pairs with the 0xFF code. Upper-half reads return zero. The update pulse follows only the link step, and nothing is accepted while the sequencer is away from idle. Other behaviour can only be shown by the bench's scenarios, which sweep every entry through every core affinity and through unmatched values. These scenarios show that reads return exactly what was written, that a move leaves other interrupts alone, that the lowest matching core is picked, and that accesses during busy and to unused offsets leave no trace.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNLINK = 2'd1,
        ST_LINK   = 2'd2
    } rt_state_e;

    localparam logic [7:0] RT_NO_CORE  = 8'hFF;
    localparam int         RT_WIN_BASE = 256;
    localparam int         RT_ENTRY_SHIFT = 3;
endpackage

// File: rtl/rt_decode.sv
module rt_decode #(
    parameter int NUM_SPI = 8,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              upper,
    output logic [IDX_W-1:0]  idx
);
    import rt_pkg::*;

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] entry;

    always_comb begin
        offs   = addr - ADDR_W'(RT_WIN_BASE);
        entry  = offs >> RT_ENTRY_SHIFT;
        in_win = (addr >= ADDR_W'(RT_WIN_BASE)) && (entry < ADDR_W'(NUM_SPI));
        upper  = offs[2];
        idx    = entry[IDX_W-1:0];
    end
endmodule

// File: rtl/rt_lookup.sv
module rt_lookup #(
    parameter int NUM_CORES = 4,
    parameter logic [NUM_CORES*32-1:0] CORE_AFF = '0,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [31:0]       aff,
    output logic              hit,
    output logic [CORE_W-1:0] core
);
    logic [NUM_CORES-1:0] eq;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
        assign eq[c] = (aff == CORE_AFF[c*32 +: 32]);
    end

    always_comb begin
        hit  = 1'b0;
        core = '0;
        for (int c = NUM_CORES - 1; c >= 0; c--) begin
            if (eq[c]) begin
                hit  = 1'b1;
                core = CORE_W'(c);
            end
        end
    end
endmodule

// File: rtl/rt_bitmap.sv
module rt_bitmap #(
    parameter int NUM_SPI   = 8,
    parameter int NUM_CORES = 4,
    localparam int IDX_W  = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_en,
    input  logic [CORE_W-1:0]            clr_core,
    input  logic                         set_en,
    input  logic [CORE_W-1:0]            set_core,
    input  logic [IDX_W-1:0]             bit_idx,
    output logic [NUM_CORES*NUM_SPI-1:0] map
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [NUM_SPI-1:0] row_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= (c == 0) ? '1 : '0;
            end else begin
                if (clr_en && clr_core == CORE_W'(c)) row_q[bit_idx] <= 1'b0;
                if (set_en && set_core == CORE_W'(c)) row_q[bit_idx] <= 1'b1;
            end
        end

        assign map[c*NUM_SPI +: NUM_SPI] = row_q;
    end
endmodule

// File: rtl/aff_route_table.sv
module aff_route_table #(
    parameter int NUM_SPI   = 8,
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16,
    parameter logic [NUM_CORES*32-1:0] CORE_AFF =
        {32'h0102_0304, 32'h0000_0100, 32'h0000_0001, 32'h0000_0000}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic                         busy,
    output logic                         rd_valid,
    output logic [31:0]                  rd_data,
    output logic [8*NUM_SPI-1:0]         tgt_idx,
    output logic [NUM_SPI-1:0]           tgt_valid,
    output logic [NUM_CORES*NUM_SPI-1:0] core_map,
    output logic                         route_changed
);
    import rt_pkg::*;

    localparam int IDX_W  = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    rt_state_e         state_q, state_d;
    logic [31:0]       aff_q [NUM_SPI];
    logic [7:0]        tgt_q [NUM_SPI];
    logic [NUM_SPI-1:0] valid_q;
    logic [IDX_W-1:0]  pend_q;

    logic              dec_in_win, dec_upper;
    logic [IDX_W-1:0]  dec_idx;
    logic              lk_hit;
    logic [CORE_W-1:0] lk_core;
    logic              accept, wr_hit;

    rt_decode #(.NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .in_win (dec_in_win),
        .upper  (dec_upper),
        .idx    (dec_idx)
    );

    rt_lookup #(.NUM_CORES(NUM_CORES), .CORE_AFF(CORE_AFF)) u_lookup (
        .aff  (aff_q[pend_q]),
        .hit  (lk_hit),
        .core (lk_core)
    );

    rt_bitmap #(.NUM_SPI(NUM_SPI), .NUM_CORES(NUM_CORES)) u_bitmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (state_q == ST_UNLINK && valid_q[pend_q]),
        .clr_core (tgt_q[pend_q][CORE_W-1:0]),
        .set_en   (state_q == ST_LINK && lk_hit),
        .set_core (lk_core),
        .bit_idx  (pend_q),
        .map      (core_map)
    );

    assign accept = bus_en && (state_q == ST_IDLE);
    assign wr_hit = accept && bus_wr && dec_in_win && !dec_upper;
    assign busy   = (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_hit) state_d = ST_UNLINK;
            ST_UNLINK: state_d = ST_LINK;
            ST_LINK:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Storage and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SPI; s++) begin
                aff_q[s] <= CORE_AFF[31:0];
                tgt_q[s] <= 8'd0;
            end
            valid_q       <= '1;
            pend_q        <= '0;
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            route_changed <= 1'b0;
        end else begin
            rd_valid      <= accept && !bus_wr;
            rd_data       <= (dec_in_win && !dec_upper) ? aff_q[dec_idx] : 32'd0;
            route_changed <= (state_q == ST_LINK);
            if (wr_hit) begin
                aff_q[dec_idx] <= bus_wdata;
                pend_q         <= dec_idx;
            end
            if (state_q == ST_LINK) begin
                tgt_q[pend_q]   <= lk_hit ? 8'(lk_core) : RT_NO_CORE;
                valid_q[pend_q] <= lk_hit;
            end
        end
    end

    for (genvar s = 0; s < NUM_SPI; s++) begin : g_out
        logic [NUM_CORES-1:0] col;
        assign tgt_idx[s*8 +: 8] = tgt_q[s];
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_col
            assign col[c] = core_map[c*NUM_SPI + s];
        end

        // R6: bitmap ownership agrees with the valid flag outside the link step
        a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q != ST_LINK) |-> ($countones(col) == int'(tgt_valid[s])));

        // R7: unroutable interrupts carry the reserved code
        a_r7_no_core_code: assert property (@(posedge clk) disable iff (!rst_n)
            !tgt_valid[s] |-> (tgt_idx[s*8 +: 8] == RT_NO_CORE));

        // R5: a routed interrupt names an existing core
        a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_valid[s] |-> (tgt_idx[s*8 +: 8] < 8'(NUM_CORES)));
    end
    assign tgt_valid = valid_q;

    // R4: upper halves read as zero
    a_r4_upper_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(bus_addr[2])) |-> (rd_data == 32'd0));

    // R8: completion pulse follows only the link step
    a_r8_pulse_after_link: assert property (@(posedge clk) disable iff (!rst_n)
        route_changed |-> ($past(state_q) == ST_LINK));

    // R8: busy lasts at least two cycles once raised
    a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R9: no read response for an access presented while busy
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);
endmodule

// File: tb/test_aff_route_table.sv
module test_aff_route_table;
    localparam int NS = 8;
    localparam int NC = 4;
    localparam int AW = 16;
    localparam logic [NC*32-1:0] TBL =
        {32'h0102_0304, 32'h0000_0100, 32'h0000_0001, 32'h0000_0000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          busy, rd_valid, route_changed;
    logic [31:0]   rd_data;
    logic [8*NS-1:0]  tgt_idx;
    logic [NS-1:0]    tgt_valid;
    logic [NC*NS-1:0] core_map;

    int checks = 0, fails = 0;
    logic [31:0] model [NS];

    always #5 clk = ~clk;

    aff_route_table #(.NUM_SPI(NS), .NUM_CORES(NC), .ADDR_W(AW), .CORE_AFF(TBL)) i_aff_route_table (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .tgt_idx(tgt_idx), .tgt_valid(tgt_valid), .core_map(core_map),
        .route_changed(route_changed)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_core(input logic [31:0] a);
        for (int c = 0; c < NC; c++) if (TBL[c*32 +: 32] == a) return c;
        return -1;
    endfunction

    task automatic check_routing(input string req);
        logic [NC*NS-1:0] em = '0;
        for (int s = 0; s < NS; s++) begin
            int c = exp_core(model[s]);
            logic [7:0] ei = (c < 0) ? 8'hFF : 8'(c);
            chk(tgt_idx[s*8 +: 8] == ei && tgt_valid[s] == (c >= 0), req,
                {55'd0, tgt_valid[s], tgt_idx[s*8 +: 8]}, {55'd0, c >= 0, ei});
            if (c >= 0) em[c*NS + s] = 1'b1;
        end
        chk(core_map == em, {req, " R6 bitmap"}, 64'(core_map), 64'(em));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [31:0] e, input string req);
        @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); @(negedge clk); bus_en = 0;
        chk(rd_valid == 1'b1 && rd_data == e, req, {31'd0, rd_valid, rd_data}, {32'd1, e});
    endtask

    task automatic do_write(input int s, input logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = AW'(256 + 8*s); bus_wdata = d;
        @(posedge clk); @(negedge clk); bus_en = 0;
        chk(busy && !route_changed, "R8 busy cycle 1", {busy, route_changed}, 2'b10);
        @(posedge clk); @(negedge clk);
        chk(busy && !route_changed, "R8 busy cycle 2", {busy, route_changed}, 2'b10);
        @(posedge clk); @(negedge clk);
        chk(!busy && route_changed, "R8 done pulse", {busy, route_changed}, 2'b01);
        model[s] = d;
        check_routing("R5/R7 after write");
        @(posedge clk); @(negedge clk);
        chk(!route_changed, "R8 pulse width", route_changed, 0);
    endtask

    task automatic ignored_write(input logic [AW-1:0] a, input string req);
        @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk); bus_en = 0;
        chk(!busy, {req, " no busy"}, busy, 0);
        check_routing(req);
    endtask

    initial begin
        for (int k = 0; k < 200000; k++) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] vals [6];
        vals[0] = 32'h0000_0001; vals[1] = 32'h0000_0100; vals[2] = 32'h0102_0304;
        vals[3] = 32'h0000_0000; vals[4] = 32'h0000_0002; vals[5] = 32'hFF01_0304;
        for (int s = 0; s < NS; s++) model[s] = TBL[31:0];
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        chk(!busy && !rd_valid && !route_changed, "R1 idle outputs",
            {busy, rd_valid, route_changed}, 0);
        check_routing("R1 reset routing");
        for (int s = 0; s < NS; s++) do_read(AW'(256 + 8*s), TBL[31:0], "R1/R2 reset read");

        // Sweep every entry through matched and unmatched values
        for (int v = 0; v < 6; v++)
            for (int s = 0; s < NS; s++) begin
                do_write(s, vals[(v + s) % 6]);
                do_read(AW'(256 + 8*s), vals[(v + s) % 6], "R3 read as written");
            end

        // R4 upper halves, private range, past the end
        for (int s = 0; s < NS; s++) begin
            do_read(AW'(260 + 8*s), 32'd0, "R4 upper read zero");
            ignored_write(AW'(260 + 8*s), "R4 upper write ignored");
        end
        do_read(AW'(0), 32'd0, "R4 private read zero");
        do_read(AW'(252), 32'd0, "R4 below window read zero");
        ignored_write(AW'(248), "R4 private write ignored");
        do_read(AW'(256 + 8*NS), 32'd0, "R4 past end read zero");
        ignored_write(AW'(256 + 8*NS), "R4 past end write ignored");
        for (int s = 0; s < NS; s++) do_read(AW'(256 + 8*s), model[s], "R4 entries untouched");

        // R9 access during busy
        @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = AW'(256); bus_wdata = 32'h0000_0001;
        @(posedge clk); @(negedge clk); bus_wr = 1; bus_addr = AW'(264); bus_wdata = 32'h0102_0304;
        @(posedge clk); @(negedge clk); bus_wr = 0; bus_addr = AW'(256);
        @(posedge clk); @(negedge clk); bus_en = 0;
        chk(!rd_valid && route_changed, "R9 read during busy ignored", {rd_valid, route_changed}, 2'b01);
        model[0] = 32'h0000_0001;
        check_routing("R9 busy write ignored");
        do_read(AW'(264), model[1], "R9 entry 1 unchanged");

        // R6 move back and forth on one entry
        do_write(3, 32'h0000_0100);
        do_write(3, 32'h0000_0100);
        do_write(3, 32'h0000_0777);
        do_write(3, 32'h0000_0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule